// File: doc/BRIEF.md
# Dual-mode PWM generator

A pulse-width modulation generator built around one counter that feeds two outputs. The equal-area output is a compare-style waveform with a fixed period: the counter steps by one, returns to zero after a programmable terminal count, and the output stays high while the count is at or below a compare value. The proportional output is the carry of an accumulator. The counter adds a duty value on every step, so the high ticks are spread through the period instead of being grouped into one pulse.

A shared prescaler sets how often the counter steps. A user picks one output for each instance. Two thin wrappers fix the unused controls, one for each mode.

Top module: `dual_pwm`

## Requirements
- R1: With a prescale value of zero, the counter advances on every clock.
- R2: With a prescale value S > 0, the counter advances once every S+1 clocks and holds its value in between. Both outputs keep their duty over clocks, so each period stretches by a factor of S+1.
- R3: On each advance, the counter adds the increment input, modulo 2^CNT_W.
- R4: When the terminal value is nonzero and the counter equals it, the next advance loads zero, giving a period of terminal+1 advances. A terminal value of zero disables this, and the counter wraps modulo 2^CNT_W.
- R5: The equal-area output is registered. One clock after the counter holds a value at or below the compare value, it reads 1; otherwise it reads 0. With increment 1, a period therefore has compare+1 high counts, or is high throughout if the compare value is at or above the terminal value.
- R6: The proportional output is the carry out of counter + increment, without a register. From zero with increment 0x80, it reads 0,1,0,1,... per advance. With increment 0 it is always 0.
- R7: With a terminal value of zero and increment D, the proportional output is high on exactly D of every 2^CNT_W advances (0xFF gives 255/256, 0x01 gives 1/256).
- R8: An active-low asynchronous reset clears the counter, the prescaler and the equal-area register. Both outputs read 0 while reset is held.
- R9: The equal-area wrapper fixes the increment at 1. The proportional wrapper ties the terminal and compare values to zero and takes the duty as its increment.
- R10: Counter width and prescaler width are independent parameters, each 8 by default. A 10-bit counter with terminal 0x3FF and compare 0x10 gives 17 high counts per 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | CNT_W | Step added to the counter on each advance |
| end_i | input | CNT_W | Terminal count; 0 means free wrap |
| match_i | input | CNT_W | Compare value for the equal-area output |
| scale_i | input | DIV_W | Prescale value; the counter advances every scale_i+1 clocks |
| ea_o | output | 1 | Registered equal-area PWM |
| pp_o | output | 1 | Proportional (carry) PWM |

## Verification
The assertions check, on every cycle, the following: the counter holds between prescaler ticks; two ticks never fall back to back when the prescale value is nonzero; a carry on a free-wrapping advance makes the count smaller; a count of zero always drives the equal-area output high one clock later; a zero increment keeps the carry output low; and both outputs read zero under reset. Only the bench scenarios can show the high-tick count per whole period (for fixed-period settings, shortened terminal counts, prescaled settings, carry densities, the wrappers and a 10-bit instance), along with the exact cycle-by-cycle sequences that follow a reset.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned DIV_W_DEF = 8;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned DIV_W = pwm_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] scale_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;

  // >= so a scale lowered mid-count still ticks at once
  assign tick_o = (pre_q >= scale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R2: a nonzero scale never yields two ticks in a row
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && scale_i != '0) |=> (!tick_o || scale_i == '0));
endmodule

// File: rtl/pwm_accum.sv
module pwm_accum #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] inc_i,
  input  logic [CNT_W-1:0] end_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;
  logic             term_hit;

  assign sum      = {1'b0, cnt_q} + {1'b0, inc_i};
  assign carry_o  = sum[CNT_W];
  assign term_hit = (end_i != '0) && (cnt_q == end_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (tick_i) begin
      if (term_hit)    cnt_q <= '0;
      else             cnt_q <= sum[CNT_W-1:0];
    end
  end

  // R2: count frozen between prescaler ticks
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

  // R7: a carry on a free-wrapping advance lowers the count
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && carry_o && end_i == '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] match_i,
  output logic             ea_o
);
  logic ea_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ea_q <= 1'b0;
    else         ea_q <= (cnt_i <= match_i);
  end

  assign ea_o = ea_q;

  // R5: count zero always opens the high phase
  p_zero_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> ea_o);
endmodule

// File: rtl/pwm_equal_area.sv
module pwm_equal_area #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF,
  parameter int unsigned DIV_W = pwm_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] end_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic [DIV_W-1:0] scale_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] StepOne = CNT_W'(1);
  logic unused_pp;

  // R9: increment fixed at one
  dual_pwm #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (StepOne),
    .end_i   (end_i),
    .match_i (match_i),
    .scale_i (scale_i),
    .ea_o    (pwm_o),
    .pp_o    (unused_pp)
  );
endmodule

// File: rtl/pwm_density.sv
module pwm_density #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF,
  parameter int unsigned DIV_W = pwm_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DIV_W-1:0] scale_i,
  output logic             pwm_o
);
  logic unused_ea;

  // R9: free wrap, compare unused
  dual_pwm #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (duty_i),
    .end_i   ('0),
    .match_i ('0),
    .scale_i (scale_i),
    .ea_o    (unused_ea),
    .pp_o    (pwm_o)
  );
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF,
  parameter int unsigned DIV_W = pwm_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] inc_i,
  input  logic [CNT_W-1:0] end_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic [DIV_W-1:0] scale_i,
  output logic             ea_o,
  output logic             pp_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt;

  pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scale_i (scale_i),
    .tick_o  (tick)
  );

  pwm_accum #(.CNT_W(CNT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .inc_i   (inc_i),
    .end_i   (end_i),
    .cnt_o   (cnt),
    .carry_o (pp_o)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt),
    .match_i (match_i),
    .ea_o    (ea_o)
  );

  // R6: zero step never carries
  p_zero_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0) |-> !pp_o);

  // R8: both outputs quiet under reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r8: assert (!ea_o && !pp_o);
    end
  end
endmodule

// File: tb/sim_dual_pwm.sv
`timescale 1ns/1ps
module sim_dual_pwm;
  typedef struct packed {
    logic [7:0]  inc;
    logic [7:0]  endv;
    logic [7:0]  match;
    logic [7:0]  scale;
    logic        sel;   // 0 equal-area, 1 proportional
    logic [15:0] win;
    logic [15:0] hi;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'hFF, 8'h10, 8'h00, 1'b0, 16'd512,  16'd34},  // R5 17/256
    '{8'h01, 8'h1F, 8'h10, 8'h00, 1'b0, 16'd64,   16'd34},  // R4 17/32
    '{8'h01, 8'hC8, 8'h64, 8'h00, 1'b0, 16'd402,  16'd202}, // R4 101/201
    '{8'h01, 8'h00, 8'h7F, 8'h00, 1'b0, 16'd512,  16'd256}, // R4 free wrap 128/256
    '{8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 16'd512,  16'd510}, // R7 255/256
    '{8'h80, 8'h00, 8'h00, 8'h01, 1'b1, 16'd1024, 16'd512}, // R2 128/256 prescale 1
    '{8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 16'd512,  16'd2},   // R7 1/256
    '{8'h01, 8'h1F, 8'h07, 8'h03, 1'b0, 16'd256,  16'd64},  // R2 8/32 prescale 3
    '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'd256,  16'd0},   // R6 zero step
    '{8'h01, 8'h0F, 8'h20, 8'h00, 1'b0, 16'd64,   16'd64}   // R5 compare above end
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] inc = '0, endv = '0, match = '0, scale = '0;
  logic       ea, pp, ea10, pp10, w_ea, w_pp;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dual_pwm u0 (.clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .end_i(endv),
               .match_i(match), .scale_i(scale), .ea_o(ea), .pp_o(pp));

  dual_pwm #(.CNT_W(10), .DIV_W(4)) u1 (.clk_i(clk), .rst_ni(rst_n),
    .inc_i(10'h001), .end_i(10'h3FF), .match_i(10'h010), .scale_i(4'h0),
    .ea_o(ea10), .pp_o(pp10));

  pwm_equal_area u2 (.clk_i(clk), .rst_ni(rst_n), .end_i(8'h1F),
    .match_i(8'h07), .scale_i(8'h00), .pwm_o(w_ea));

  pwm_density u3 (.clk_i(clk), .rst_ni(rst_n), .duty_i(8'h40),
    .scale_i(8'h02), .pwm_o(w_pp));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic count_hi(input int src, input int win, output int hi);
    hi = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      case (src)
        0: hi += int'(ea);
        1: hi += int'(pp);
        2: hi += int'(ea10);
        3: hi += int'(w_ea);
        default: hi += int'(w_pp);
      endcase
    end
  endtask

  initial begin
    int hi;
    // R8: outputs cleared while reset held, with a carrying step applied
    inc = 8'hFF; endv = 8'h00; match = 8'h10;
    repeat (3) @(negedge clk);
    chk("R8 ea in reset", int'(ea), 0);
    chk("R8 pp in reset", int'(pp), 0);
    rst_n = 1'b1;

    // duty table
    for (int v = 0; v < NV; v++) begin
      inc = VECS[v].inc; endv = VECS[v].endv;
      match = VECS[v].match; scale = VECS[v].scale;
      do_reset();
      count_hi(VECS[v].sel ? 1 : 0, int'(VECS[v].win), hi);
      chk($sformatf("R1/R3 vector %0d duty", v), hi, int'(VECS[v].hi));
    end

    // R6: carry sequence from zero, step 0x80, no prescale
    inc = 8'h80; endv = 8'h00; scale = 8'h00;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R6 pp seq %0d", k), int'(pp), k % 2);
      @(negedge clk);
    end

    // R5: registered compare sequence, end 7, compare 2
    inc = 8'h01; endv = 8'h07; match = 8'h02;
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chk($sformatf("R5 ea seq %0d", k), int'(ea), (k <= 3 || k == 9) ? 1 : 0);
    end

    // R10: 10-bit counter 17/1024
    do_reset();
    count_hi(2, 2048, hi);
    chk("R10 10-bit duty", hi, 34);

    // R9: wrappers
    do_reset();
    count_hi(3, 64, hi);
    chk("R9 equal-area wrapper", hi, 16);
    do_reset();
    count_hi(4, 768, hi);
    chk("R9 density wrapper", hi, 192);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule